// File: doc/BRIEF.md
# Peripheral Chip Select Generator

This block turns a bus address into six active-low peripheral select lines. Each line owns a 256-byte window placed at a fixed offset from a programmable base. The base is aligned to a 2 KB boundary. Decoding can be done against the 20-bit memory address or the 16-bit I/O address. The block also produces the ready signal for the bus unit. That signal holds each decoded access for a programmed number of wait states. It can also wait for the external ready input.

Software writes two words through one write port:

- **Main word** (`cfg_sel` = 0): holds the base, the wait-state code and the ready mode. The first write of this word also arms the selects.
- **Mode word** (`cfg_sel` = 1): chooses between memory space and I/O space.

The bus unit holds `cyc_act` high for the whole access and drops it for at least one cycle between accesses. The selects follow the address combinationally. The wait counter starts on the first clock of a decoded access.

Top module: `pcs_gen`

## Requirements
- R1: After reset all of `pcs_n` are high and `rdy_o` is high. No select asserts, whatever the bus does, until the main word (`cfg_sel`=0) has been written once.
- R2: Main-word bits 15..7 give base address bits 19..11. In memory space a select asserts only when `addr[19:11]` equals that field.
- R3: Inside the 2 KB block, offset 0x000–0x0FF drives `pcs_n[0]` low, 0x100–0x1FF drives `pcs_n[1]`, 0x200–0x2FF drives `pcs_n[2]` and 0x300–0x3FF drives `pcs_n[3]`. At most one line is low at a time.
- R4: Offset 0x500–0x5FF drives `pcs_n[4]` low and 0x600–0x6FF drives `pcs_n[5]`. Offsets 0x400–0x4FF and 0x700–0x7FF drive no line.
- R5: Mode-word bit 0 = 1 maps the selects to I/O space. Only `addr[15:11]` is then compared, against base bits 15..11, and `addr[19:16]` is ignored. A select asserts only when `io_cyc` (1 = I/O cycle) equals the programmed space.
- R6: Selects are asserted only while `cyc_act` is high. `rdy_o` is high whenever no select is asserted.
- R7: For `pcs_n[3:0]`, the code {bit3, bit1, bit0} of the main word gives the wait count: 000→0, 001→1, 010→2, 011→3, 100→5, 101→7, 110→9, 111→15.
- R8: For `pcs_n[5:4]`, only {bit1, bit0} are used, as a plain count from 0 to 3.
- R9: With W waits, in cycle k of an access (k = 0 is the first cycle) `rdy_o` is high only when k ≥ W. Main-word bit 2 = 1 ignores `ext_rdy`. Bit 2 = 0 also requires `ext_rdy` high in that cycle.
- R10: Main-word bits 6..4 have no effect on selects or ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = main word, 1 = mode word |
| cfg_wdata | input | 16 | Configuration write data |
| addr | input | 20 | Bus address |
| cyc_act | input | 1 | Bus cycle active |
| io_cyc | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| ext_rdy | input | 1 | External ready |
| pcs_n | output | 6 | Active-low peripheral selects |
| rdy_o | output | 1 | Ready to the bus unit |

## Verification
The select lines and `rdy_o` are combinational in the current bus inputs. They are therefore due in the same cycle the address, strobe and `ext_rdy` are applied. The bench drives these inputs just after a rising edge and samples at the following falling edge. The wait counter adds latency in whole cycles. For each cycle k of an access, the driver computes from its own model whether k ≥ W and whether ready is honoured, and queues that expectation. The monitor compares each queued entry at the falling edge of that same cycle. Configuration writes take effect from the cycle after the write edge, so accesses start only after the write has completed.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned CNT_W  = 4;

  // non-linear wait table for the lower selects
  function automatic logic [CNT_W-1:0] wait_full(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] w;
    case (code)
      3'd0: w = 4'd0;
      3'd1: w = 4'd1;
      3'd2: w = 4'd2;
      3'd3: w = 4'd3;
      3'd4: w = 4'd5;
      3'd5: w = 4'd7;
      3'd6: w = 4'd9;
      default: w = 4'd15;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/pcs_cfg_reg.sv
module pcs_cfg_reg #(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned BASE_W = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic                       cfg_sel,
  input  logic [REG_W-1:0]           cfg_wdata,
  output logic [BASE_W-1:0]          base_o,
  output logic [pcs_pkg::CODE_W-1:0] code_o,
  output logic                       ign_rdy_o,
  output logic                       io_map_o,
  output logic                       enabled_o
);
  logic [BASE_W-1:0]          base_q, base_d;
  logic [pcs_pkg::CODE_W-1:0] code_q, code_d;
  logic                       ign_q, ign_d, io_q, io_d, en_q, en_d;
  logic                       main_we, mode_we;

  assign main_we = cfg_we && !cfg_sel;
  assign mode_we = cfg_we && cfg_sel;

  always_comb begin
    base_d = base_q;
    code_d = code_q;
    ign_d  = ign_q;
    io_d   = io_q;
    en_d   = en_q;
    if (main_we) begin
      base_d = cfg_wdata[REG_W-1 -: BASE_W];
      code_d = {cfg_wdata[3], cfg_wdata[1:0]};
      ign_d  = cfg_wdata[2];
      en_d   = 1'b1;
    end
    if (mode_we) io_d = cfg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      code_q <= '0;
      ign_q  <= 1'b0;
      io_q   <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      base_q <= base_d;
      code_q <= code_d;
      ign_q  <= ign_d;
      io_q   <= io_d;
      en_q   <= en_d;
    end
  end

  assign base_o    = base_q;
  assign code_o    = code_q;
  assign ign_rdy_o = ign_q;
  assign io_map_o  = io_q;
  assign enabled_o = en_q;

  assert_write_arms_R1: assert property (@(posedge clk) disable iff (!rst_n)
    main_we |=> enabled_o);
  assert_arm_sticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    enabled_o |=> enabled_o);
endmodule

// File: rtl/pcs_addr_decode.sv
module pcs_addr_decode #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned IO_W    = 16,
  parameter int unsigned WIN_W   = 8,
  parameter int unsigned NUM_SEL = 6,
  parameter int unsigned LOW_SEL = 4,
  parameter int unsigned BASE_W  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               cyc_act,
  input  logic               io_cyc,
  input  logic [BASE_W-1:0]  base,
  input  logic               io_map,
  input  logic               enabled,
  output logic [NUM_SEL-1:0] sel_o,
  output logic               upper_o
);
  localparam int unsigned BLK_LSB = ADDR_W - BASE_W;
  localparam int unsigned SLOT_W  = BLK_LSB - WIN_W;
  localparam int unsigned IO_HI   = IO_W - BLK_LSB;

  logic [SLOT_W-1:0] slot;
  logic              mem_match, io_match, blk_hit;

  assign slot      = addr[BLK_LSB-1:WIN_W];
  assign mem_match = addr[ADDR_W-1:BLK_LSB] == base;
  assign io_match  = addr[IO_W-1:BLK_LSB] == base[IO_HI-1:0];
  assign blk_hit   = enabled && cyc_act && (io_cyc == io_map) &&
                     (io_map ? io_match : mem_match);

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_win
    // one window is skipped between the lower and upper groups
    localparam int unsigned SLOT = (i < LOW_SEL) ? i : i + 1;
    assign sel_o[i] = blk_hit && (slot == SLOT_W'(SLOT));
  end

  assign upper_o = |sel_o[NUM_SEL-1:LOW_SEL];

  assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));
  assert_strobe_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_act |-> (sel_o == '0));
  assert_unarmed_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> (sel_o == '0));
endmodule

// File: rtl/pcs_wait_ctrl.sv
module pcs_wait_ctrl (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hit,
  input  logic                       upper,
  input  logic [pcs_pkg::CODE_W-1:0] code,
  input  logic                       ign_rdy,
  input  logic                       ext_rdy,
  output logic                       rdy_o
);
  import pcs_pkg::*;

  logic [CNT_W-1:0] waits, load_val, cnt_q, cnt_d;
  logic             act_q, start, rdy_ok, cnt_zero;

  assign waits    = upper ? {{(CNT_W-2){1'b0}}, code[1:0]} : wait_full(code);
  assign load_val = (waits == '0) ? '0 : waits - 1'b1;
  assign start    = hit && !act_q;
  assign rdy_ok   = ign_rdy || ext_rdy;
  assign cnt_zero = start ? (waits == '0) : (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= hit;
    end
  end

  assign rdy_o = !hit || (cnt_zero && rdy_ok);

  assert_idle_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> rdy_o);
  assert_count_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act_q && cnt_q != '0) |-> !rdy_o);
  assert_count_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act_q && cnt_q != '0) |=> (!hit || cnt_q == $past(cnt_q) - 1'b1));
  assert_ext_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act_q && ign_rdy && cnt_q == '0) |-> rdy_o);
endmodule

// File: rtl/pcs_gen.sv
module pcs_gen #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned IO_W    = 16,
  parameter int unsigned REG_W   = 16,
  parameter int unsigned WIN_W   = 8,
  parameter int unsigned NUM_SEL = 6,
  parameter int unsigned LOW_SEL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [REG_W-1:0]   cfg_wdata,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               cyc_act,
  input  logic               io_cyc,
  input  logic               ext_rdy,
  output logic [NUM_SEL-1:0] pcs_n,
  output logic               rdy_o
);
  localparam int unsigned BLK_LSB = WIN_W + 3;
  localparam int unsigned BASE_W  = ADDR_W - BLK_LSB;

  logic [BASE_W-1:0]          base;
  logic [pcs_pkg::CODE_W-1:0] code;
  logic                       ign_rdy, io_map, enabled, upper;
  logic [NUM_SEL-1:0]         sel;

  pcs_cfg_reg #(.REG_W(REG_W), .BASE_W(BASE_W)) i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .base_o(base), .code_o(code),
    .ign_rdy_o(ign_rdy), .io_map_o(io_map), .enabled_o(enabled));

  pcs_addr_decode #(.ADDR_W(ADDR_W), .IO_W(IO_W), .WIN_W(WIN_W),
    .NUM_SEL(NUM_SEL), .LOW_SEL(LOW_SEL), .BASE_W(BASE_W)) i_dec (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cyc_act(cyc_act),
    .io_cyc(io_cyc), .base(base), .io_map(io_map), .enabled(enabled),
    .sel_o(sel), .upper_o(upper));

  pcs_wait_ctrl i_wait (
    .clk(clk), .rst_n(rst_n), .hit(|sel), .upper(upper), .code(code),
    .ign_rdy(ign_rdy), .ext_rdy(ext_rdy), .rdy_o(rdy_o));

  assign pcs_n = ~sel;
endmodule

// File: tb/test_pcs_gen.sv
module test_pcs_gen;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [5:0] pcs;
    logic       rdy;
    string      req;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [19:0] addr = '0;
  logic        cyc_act = 1'b0, io_cyc = 1'b0, ext_rdy = 1'b0;
  logic [5:0]  pcs_n;
  logic        rdy_o;

  int   n_run = 0, n_fail = 0;
  bit   done = 0;
  exp_t q[$];

  logic [8:0] m_base = '0;
  logic [2:0] m_code = '0;
  logic       m_ign = 0, m_io = 0, m_en = 0;

  pcs_gen i_pcs_gen (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .addr(addr), .cyc_act(cyc_act), .io_cyc(io_cyc),
    .ext_rdy(ext_rdy), .pcs_n(pcs_n), .rdy_o(rdy_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int tbl(input logic [2:0] c);
    int t[8] = '{0, 1, 2, 3, 5, 7, 9, 15};
    return t[c];
  endfunction

  function automatic int model_sel(input logic [19:0] a, input logic io);
    int off;
    bit match;
    if (!m_en || io != m_io) return -1;
    match = m_io ? (a[15:11] == m_base[4:0]) : (a[19:11] == m_base);
    if (!match) return -1;
    off = int'(a[10:8]);
    if (off < 4) return off;
    if (off == 5 || off == 6) return off - 1;
    return -1;
  endfunction

  // monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (pcs_n !== e.pcs || rdy_o !== e.rdy) begin
        n_fail++;
        $display("FAIL %s: pcs_n=%b rdy=%b expected pcs_n=%b rdy=%b",
                 e.req, pcs_n, rdy_o, e.pcs, e.rdy);
      end
    end
  end

  task automatic push(input logic [5:0] p, input logic r, input string req);
    exp_t e;
    e.pcs = p; e.rdy = r; e.req = req;
    q.push_back(e);
  endtask

  task automatic wr_main(input logic [19:0] base_addr, input logic [2:0] code,
                         input logic ign, input logic [2:0] rsv);
    @(posedge clk); #1;
    cyc_act = 0; cfg_we = 1; cfg_sel = 0;
    cfg_wdata = {base_addr[19:11], rsv, code[2], ign, code[1:0]};
    @(posedge clk); #1;
    cfg_we = 0;
    m_base = base_addr[19:11]; m_code = code; m_ign = ign; m_en = 1;
  endtask

  task automatic wr_mode(input logic io);
    @(posedge clk); #1;
    cyc_act = 0; cfg_we = 1; cfg_sel = 1; cfg_wdata = {15'd0, io};
    @(posedge clk); #1;
    cfg_we = 0; cfg_sel = 0;
    m_io = io;
  endtask

  task automatic access(input logic [19:0] a, input logic io, input logic strobe,
                        input int hold, input int rdy_at, input string req);
    int s = strobe ? model_sel(a, io) : -1;
    int w = (s >= 4) ? int'(m_code[1:0]) : tbl(m_code);
    for (int k = 0; k < hold; k++) begin
      @(posedge clk); #1;
      addr = a; io_cyc = io; cyc_act = strobe; ext_rdy = (k >= rdy_at);
      if (s < 0) push(6'h3F, 1'b1, req);
      else push(~(6'd1 << s), (k >= w) && (m_ign || ext_rdy), req);
    end
    @(posedge clk); #1;
    cyc_act = 0;
    push(6'h3F, 1'b1, req);
  endtask

  localparam logic [19:0] B = 20'h8A800;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state and unarmed block
    access(B, 0, 1, 2, 0, "R1");
    access(B + 20'h100, 0, 1, 2, 0, "R1");
    wr_main(B, 3'd0, 1'b1, 3'd0);
    // R3 lower windows, R4 gap and upper windows
    access(B + 20'h000, 0, 1, 2, 0, "R3");
    access(B + 20'h1FF, 0, 1, 2, 0, "R3");
    access(B + 20'h280, 0, 1, 2, 0, "R3");
    access(B + 20'h3FF, 0, 1, 2, 0, "R3");
    access(B + 20'h400, 0, 1, 2, 0, "R4");
    access(B + 20'h4FF, 0, 1, 2, 0, "R4");
    access(B + 20'h500, 0, 1, 2, 0, "R4");
    access(B + 20'h6FF, 0, 1, 2, 0, "R4");
    access(B + 20'h700, 0, 1, 2, 0, "R4");
    // R2: base compare on all upper bits
    access(B + 20'h800, 0, 1, 2, 0, "R2");
    access(B ^ 20'h80000, 0, 1, 2, 0, "R2");
    access(B - 20'h001, 0, 1, 2, 0, "R2");
    // R6: no strobe, no select
    access(B + 20'h100, 0, 0, 2, 0, "R6");
    // R5 mismatch on space flag in memory mode
    access(B + 20'h100, 1, 1, 2, 0, "R5");
    // R7 / R8: every code, ready ignored
    for (int c = 0; c < 8; c++) begin
      wr_main(B, 3'(c), 1'b1, 3'd0);
      access(B + 20'h300, 0, 1, tbl(3'(c)) + 2, 0, "R7");
      access(B + 20'h600, 0, 1, 5, 0, "R8");
    end
    // R9: external ready honoured
    wr_main(B, 3'd2, 1'b0, 3'd0);
    access(B + 20'h000, 0, 1, 7, 5, "R9");
    access(B + 20'h000, 0, 1, 4, 0, "R9");
    wr_main(B, 3'd5, 1'b0, 3'd0);
    access(B + 20'h200, 0, 1, 9, 3, "R9");
    access(B + 20'h500, 0, 1, 6, 4, "R9");
    // R9: external ready ignored while low
    wr_main(B, 3'd3, 1'b1, 3'd0);
    access(B + 20'h100, 0, 1, 6, 99, "R9");
    // R10: reserved bits have no effect
    wr_main(B, 3'd4, 1'b1, 3'd7);
    access(B + 20'h100, 0, 1, 7, 0, "R10");
    access(B + 20'h500, 0, 1, 4, 0, "R10");
    access(B + 20'h400, 0, 1, 2, 0, "R10");
    // R5: I/O mapping
    wr_main(20'h0A800, 3'd1, 1'b1, 3'd0);
    wr_mode(1'b1);
    access(20'hFA900, 1, 1, 3, 0, "R5");
    access(20'h0AD00, 1, 1, 3, 0, "R5");
    access(20'h0A900, 0, 1, 2, 0, "R5");
    access(20'h0B100, 1, 1, 2, 0, "R5");
    wr_mode(1'b0);
    access(20'hFA900, 0, 1, 2, 0, "R5");
    access(20'h0A900, 0, 1, 3, 0, "R5");
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule